// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a client that issues single read and write requests and a four-bank double-data-rate SDRAM. It turns each request into the command sequence the memory needs. For every bank it records whether a row is open and which row that is. A request to a closed bank produces a row activation followed by the column access. A request to an open bank that names a different row first closes that row, then activates the new one, then performs the access. A request that hits the open row goes straight to the column access. An optional per-request auto-precharge flag closes the row by itself once the burst has finished.

Each bank has its own down-counter that holds back the next command to that bank until the activate-to-access, precharge and refresh recovery times have passed. A request to one bank therefore never waits on another bank's timer. A refresh timer, sized from the clock frequency and the required average refresh interval, raises a pending flag. While the flag is set no new request is accepted. Once every bank timer has expired, the block closes all open rows with a single precharge-all command and then issues an auto refresh.

The request port uses a valid/ready handshake, and one request is in flight at a time. Command pins change only on rising clock edges and come straight from registers. The reset input is asynchronous and active low, and it must be released synchronously to the clock.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted the pins carry NOP with BA and A zero, and the clock-enable pin is low; it goes high on the first rising edge after reset and stays high.
- R2: Commands are driven as (cs_n, ras_n, cas_n, we_n): activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, NOP 0111; NOP, refresh and precharge-all carry BA = 0.
- R3: req_ready is high exactly when no request is in flight and no refresh is pending; a request is taken on a rising edge with req_valid and req_ready both high.
- R4: A request to a bank with no open row produces activate with BA = bank and A[ROW_W-1:0] = row (upper bits zero) on the edge after acceptance, or later if that bank's timer is still running.
- R5: The read or write follows its activate by exactly T_RCD cycles, whether or not auto precharge is requested (RAS lockout).
- R6: A request that hits the open row of its bank produces read or write on the edge after acceptance with BA = bank, A[COL_W-1:0] = column, A10 = auto-precharge flag, all other address bits zero.
- R7: A request to an open bank naming another row produces precharge with A10 = 0 and BA = bank; the activate for the new row follows T_RP cycles later.
- R8: A read or write with A10 set leaves the bank closed, and the next activate to that bank comes no earlier than BURST_LEN/2 + T_RP cycles after it.
- R9: A refresh becomes pending every REF_CYC = CLK_MHZ*REF_NS/1000 cycles after reset; successive auto refresh commands are spaced by REF_CYC plus at most the time to finish the request in flight.
- R10: With a refresh pending and every bank timer expired, the block issues precharge with A10 = 1 if any row is open, then auto refresh T_RP cycles later; after refresh no bank command is issued for T_RFC cycles.
- R11: A bank whose own timer has expired is served at once even while another bank is still in its auto-precharge recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column of the burst |
| req_autopre | input | 1 | Close the row after the burst |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row, column and A10 flag |
| cke | output | 1 | Clock enable |

## Verification
Directed requests first exercise a cold miss, a row hit, a row conflict and an auto-precharge access followed by a reuse of the same bank. These separate the four paths through the bank decision and show that the activate-to-access and precharge recovery spacings are applied. A request to a second bank issued just after an auto-precharge access shows that banks are timed independently. Idle stretches with rows left open make the refresh timer force precharge-all and refresh. A random stream over few rows then mixes hits, conflicts and refresh collisions, and every cycle is compared against a behavioural model.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WORK = 1'b1
  } seq_state_e;

  localparam int unsigned AP_BIT = 10;
endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 13,
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             close,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             idle
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    tmr_d  = tmr_q;
    if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
    if (load)        tmr_d = load_val;
    if (close)       open_d = 1'b0;
    if (open_set) begin
      open_d = 1'b1;
      row_d  = row_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      tmr_q  <= '0;
    end else begin
      open_q <= open_d;
      row_q  <= row_d;
      tmr_q  <= tmr_d;
    end
  end

  assign is_open  = open_q;
  assign open_row = row_q;
  assign idle     = (tmr_q == '0);
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic ref_due
);
  localparam int CNT_W = (REF_CYC > 2) ? $clog2(REF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             due_q, due_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (wrap)          due_d = 1'b1;
    else if (ref_done) due_d = 1'b0;
    else               due_d = due_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign ref_due = due_q;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 14,
  parameter int CLK_MHZ   = 200,
  parameter int REF_NS    = 7800,
  localparam int BA_W     = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke
);
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;
  localparam int T_AP    = BURST_LEN / 2 + T_RP;
  localparam int T_MAX1  = (T_RFC > T_AP) ? T_RFC : T_AP;
  localparam int T_MAX   = (T_MAX1 > T_RCD) ? T_MAX1 : T_RCD;
  localparam int TMR_W   = $clog2(T_MAX + 1);
  localparam logic [TMR_W-1:0] L_RCD = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] L_RP  = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] L_AP  = TMR_W'(T_AP - 1);
  localparam logic [TMR_W-1:0] L_RFC = TMR_W'(T_RFC - 1);

  seq_state_e        state_q, state_d;
  sdram_cmd_e        cmd_q, cmd_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              cke_q;

  logic              h_write, h_ap;
  logic [BA_W-1:0]   h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic              take;

  logic [BANKS-1:0]  b_open, b_idle, b_set, b_close, b_load;
  logic [ROW_W-1:0]  b_row [BANKS];
  logic [TMR_W-1:0]  b_val [BANKS];
  logic              ref_due, ref_done;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    sdram_bank_slot #(.ROW_W(ROW_W), .TMR_W(TMR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_set (b_set[g]),
      .close    (b_close[g]),
      .load     (b_load[g]),
      .load_val (b_val[g]),
      .row_in   (h_row),
      .is_open  (b_open[g]),
      .open_row (b_row[g]),
      .idle     (b_idle[g])
    );
  end

  sdram_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_done (ref_done),
    .ref_due  (ref_due)
  );

  assign req_ready = (state_q == SEQ_IDLE) && !ref_due;

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    take     = 1'b0;
    ref_done = 1'b0;
    b_set    = '0;
    b_close  = '0;
    b_load   = '0;
    for (int i = 0; i < BANKS; i++) b_val[i] = '0;

    if (state_q == SEQ_IDLE) begin
      if (ref_due) begin
        if (&b_idle) begin
          if (|b_open) begin
            cmd_d          = CMD_PRE;
            addr_d[AP_BIT] = 1'b1;
            b_close        = '1;
            b_load         = '1;
            for (int i = 0; i < BANKS; i++) b_val[i] = L_RP;
          end else begin
            cmd_d    = CMD_REF;
            ref_done = 1'b1;
            b_load   = '1;
            for (int i = 0; i < BANKS; i++) b_val[i] = L_RFC;
          end
        end
      end else if (req_valid) begin
        take    = 1'b1;
        state_d = SEQ_WORK;
      end
    end else if (b_idle[h_bank]) begin
      ba_d = h_bank;
      if (b_open[h_bank] && (b_row[h_bank] == h_row)) begin
        cmd_d               = h_write ? CMD_WR : CMD_RD;
        addr_d[COL_W-1:0]   = h_col;
        addr_d[AP_BIT]      = h_ap;
        state_d             = SEQ_IDLE;
        if (h_ap) begin
          b_close[h_bank] = 1'b1;
          b_load[h_bank]  = 1'b1;
          b_val[h_bank]   = L_AP;
        end
      end else if (b_open[h_bank]) begin
        cmd_d           = CMD_PRE;
        b_close[h_bank] = 1'b1;
        b_load[h_bank]  = 1'b1;
        b_val[h_bank]   = L_RP;
      end else begin
        cmd_d             = CMD_ACT;
        addr_d[ROW_W-1:0] = h_row;
        b_set[h_bank]     = 1'b1;
        b_load[h_bank]    = 1'b1;
        b_val[h_bank]     = L_RCD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      cke_q   <= 1'b0;
      h_write <= 1'b0;
      h_ap    <= 1'b0;
      h_bank  <= '0;
      h_row   <= '0;
      h_col   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      cke_q   <= 1'b1;
      if (take) begin
        h_write <= req_write;
        h_ap    <= req_autopre;
        h_bank  <= req_bank;
        h_row   <= req_row;
        h_col   <= req_col;
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign cke  = cke_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int BANKS  = 4,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int T_RCD  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              cke
);
  logic [3:0]       pins;
  logic [BANKS-1:0] opened;
  logic [7:0]       since_act [BANKS];
  logic             is_act, is_rw, is_pre, is_ref;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (pins == 4'b0011);
  assign is_rw  = (pins == 4'b0101) || (pins == 4'b0100);
  assign is_pre = (pins == 4'b0010);
  assign is_ref = (pins == 4'b0001);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opened <= '0;
      for (int i = 0; i < BANKS; i++) since_act[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < BANKS; i++) begin
        if (is_act && (ba == BA_W'(i)))   since_act[i] <= 8'd1;
        else if (since_act[i] != 8'hFF)   since_act[i] <= since_act[i] + 8'd1;
      end
      if (is_act) opened[ba] <= 1'b1;
      if (is_rw && addr[10]) opened[ba] <= 1'b0;
      if (is_pre) begin
        if (addr[10]) opened <= '0;
        else          opened[ba] <= 1'b0;
      end
    end
  end

  p_cke_hold_r1: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke);
  p_act_closed_r4: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> !opened[ba]);
  p_rcd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                                 is_rw |-> (since_act[ba] >= 8'(T_RCD)));
  p_rw_open_r6: assert property (@(posedge clk) disable iff (!rst_n) is_rw |-> opened[ba]);
  p_ref_closed_r10: assert property (@(posedge clk) disable iff (!rst_n) is_ref |-> (opened == '0));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .BANKS(BANKS), .BA_W(BA_W), .ADDR_W(ADDR_W), .T_RCD(T_RCD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .cke(cke)
);

// File: tb/sdram_cmd_seq_test.sv
module sdram_cmd_seq_test;
  localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, BL = 4;
  localparam int CLK_MHZ = 200, REF_NS = 1000;
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;
  localparam int T_AP = BL / 2 + T_RP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0] ba;
  logic [12:0] addr;

  always #2.5 clk = ~clk;

  sdram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .BURST_LEN(BL),
                  .CLK_MHZ(CLK_MHZ), .REF_NS(REF_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cke(cke)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_NOP = 4'b0111;
  int  n;
  bit  m_busy, m_pend;
  bit  op [4];
  int  orow [4];
  int  free_at [4];
  bit  h_wr, h_ap;
  int  h_b, h_row, h_col;
  logic [3:0]  e_cmd;
  logic [1:0]  e_ba;
  logic [12:0] e_addr;
  bit e_ready, e_cke;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0; m_busy = 0; m_pend = 0;
      for (int b = 0; b < 4; b++) begin op[b] = 0; orow[b] = 0; free_at[b] = 0; end
      e_cmd = C_NOP; e_ba = 0; e_addr = 0; e_ready = 1; e_cke = 0;
    end else begin
      bit clr, all_free, any_open;
      n++;
      clr = 0;
      e_cmd = C_NOP; e_ba = 0; e_addr = 0; e_cke = 1;
      if (!m_busy) begin
        if (m_pend) begin
          all_free = 1; any_open = 0;
          for (int b = 0; b < 4; b++) begin
            if (n < free_at[b]) all_free = 0;
            if (op[b]) any_open = 1;
          end
          if (all_free) begin
            if (any_open) begin
              e_cmd = C_PRE; e_addr = 13'h400;
              for (int b = 0; b < 4; b++) begin op[b] = 0; free_at[b] = n + T_RP; end
            end else begin
              e_cmd = C_REF; clr = 1;
              for (int b = 0; b < 4; b++) free_at[b] = n + T_RFC;
            end
          end
        end else if (req_valid) begin
          m_busy = 1; h_wr = req_write; h_ap = req_autopre;
          h_b = req_bank; h_row = req_row; h_col = req_col;
        end
      end else if (n >= free_at[h_b]) begin
        e_ba = h_b[1:0];
        if (op[h_b] && orow[h_b] == h_row) begin
          e_cmd = h_wr ? C_WR : C_RD;
          e_addr = 13'(h_col) | (h_ap ? 13'h400 : 13'h0);
          m_busy = 0;
          if (h_ap) begin op[h_b] = 0; free_at[h_b] = n + T_AP; end
        end else if (op[h_b]) begin
          e_cmd = C_PRE; op[h_b] = 0; free_at[h_b] = n + T_RP;
        end else begin
          e_cmd = C_ACT; e_addr = 13'(h_row);
          op[h_b] = 1; orow[h_b] = h_row; free_at[h_b] = n + T_RCD;
        end
      end
      if (n % REF_CYC == 0) m_pend = 1;
      else if (clr) m_pend = 0;
      e_ready = !m_busy && !m_pend;
    end
  end

  function automatic string req_of(logic [3:0] c, logic a10);
    case (c)
      C_ACT: return "R2/R4";
      C_RD, C_WR: return "R2/R6";
      C_PRE: return a10 ? "R2/R10" : "R2/R7";
      C_REF: return "R2/R9";
      default: return "R2/R5";
    endcase
  endfunction

  // ---------------- monitor: model compare and port-level rules ----------------
  int mc = 0;
  int last_kind [4];   // 0 none, 1 act, 2 access with auto precharge, 3 precharge, 4 plain access
  int last_t [4];
  bit mopen [4];
  int ref_count = 0, last_ref = -1;
  bit overlap_seen = 0, prea_seen = 0;

  initial for (int b = 0; b < 4; b++) begin last_kind[b] = 0; last_t[b] = 0; mopen[b] = 0; end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] oc;
      int b;
      mc++;
      oc = {cs_n, ras_n, cas_n, we_n};
      b = ba;
      chk({oc, ba, addr} === {e_cmd, e_ba, e_addr}, req_of(e_cmd, e_addr[10]),
          "cmd/ba/addr", {13'h0, oc, ba, addr}, {13'h0, e_cmd, e_ba, e_addr});
      chk(req_ready === e_ready, "R3", "req_ready", 32'(req_ready), 32'(e_ready));
      chk(cke === e_cke, "R1", "cke", 32'(cke), 32'(e_cke));
      if (oc == C_ACT) begin
        if (last_kind[b] == 2)
          chk(mc - last_t[b] >= T_AP, "R8", "auto-precharge to activate gap", mc - last_t[b], T_AP);
        if (last_kind[b] == 3)
          chk(mc - last_t[b] >= T_RP, "R7", "precharge to activate gap", mc - last_t[b], T_RP);
        for (int c = 0; c < 4; c++)
          if (c != b && last_kind[c] == 2 && mc - last_t[c] < T_AP) overlap_seen = 1;
        last_kind[b] = 1; last_t[b] = mc; mopen[b] = 1;
      end else if (oc == C_RD || oc == C_WR) begin
        if (last_kind[b] == 1)
          chk(mc - last_t[b] == T_RCD, "R5", "activate to access gap", mc - last_t[b], T_RCD);
        last_kind[b] = addr[10] ? 2 : 4; last_t[b] = mc;
        if (addr[10]) mopen[b] = 0;
      end else if (oc == C_PRE) begin
        if (addr[10]) begin
          prea_seen = 1;
          for (int c = 0; c < 4; c++) begin last_kind[c] = 3; last_t[c] = mc; mopen[c] = 0; end
        end else begin
          last_kind[b] = 3; last_t[b] = mc; mopen[b] = 0;
        end
      end else if (oc == C_REF) begin
        chk(!(mopen[0] | mopen[1] | mopen[2] | mopen[3]), "R10", "open bank at refresh", 1, 0);
        if (last_ref >= 0)
          chk((mc - last_ref <= REF_CYC + 40) && (mc - last_ref >= REF_CYC - 40), "R9",
              "refresh spacing", mc - last_ref, REF_CYC);
        last_ref = mc; ref_count++;
      end
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 60000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 60000", wd);
      finish_up();
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(bit wr, int bank, int row, int col, bit ap);
    bit r;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = 2'(bank);
    req_row = 13'(row); req_col = 10'(col); req_autopre = ap;
    forever begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
    req_valid = 0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1: reset state at the pins
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "cmd in reset", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
    chk(addr == 0 && ba == 0, "R1", "address in reset", {ba, addr}, 0);
    rst_n = 1;
    idle(2);
    send(0, 0, 5, 8, 0);     // R4 cold miss, R5 spacing
    idle(8);
    send(0, 0, 5, 9, 0);     // R6 row hit
    idle(4);
    send(1, 0, 7, 3, 0);     // R7 row conflict
    idle(12);
    send(1, 1, 3, 100, 1);   // R5 lockout with auto precharge
    send(0, 1, 3, 101, 0);   // R8 reuse of the precharging bank
    idle(10);
    send(1, 2, 9, 4, 1);     // R11 second bank served during recovery
    send(0, 3, 1, 6, 0);
    idle(2 * REF_CYC);       // R9/R10 refresh with rows open
    for (int i = 0; i < 300; i++) begin
      send($urandom % 2, $urandom % 4, $urandom % 3, $urandom % 1024, ($urandom % 4) == 0);
      idle($urandom % 4);
    end
    idle(20);
    chk(overlap_seen, "R11", "activate during another bank's recovery", overlap_seen, 1);
    chk(prea_seen, "R10", "precharge-all issued", prea_seen, 1);
    chk(ref_count >= 10, "R9", "refresh count", ref_count, 10);
    finish_up();
  end
endmodule